// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Global Enable

This block decides when a small processor core is interrupted and by which of four sources. Each source raises a request line; the block remembers every request until it is granted, whether or not interrupts are currently allowed. A single global enable bit gates recognition. When the enable is set, at least one request is held, and the core signals that an instruction has just retired, the block grants the most urgent held source. It then runs a fixed entry sequence: a one-cycle arbitration slot, two handshaked pushes of the return address to the stack unit (low byte, then high byte), a one-cycle vector fetch, and a closing slot in which the global enable is dropped.

The core uses a set-enable command to allow interrupts and a return command to leave a service routine. The return command restores the global enable. Because the set-enable command is honoured inside a service routine, a routine may permit nesting. A small saturating nesting count drives the in-service indicator.

Top module: `irq_prio_ctl`

## Requirements
- R1: After reset, `gie_o`, `push_req_o`, `vec_valid_o` and `in_service_o` are all 0.
- R2: A request pulse of a single cycle is held pending until that source is granted, and is serviced later once the enable is set.
- R3: While `gie_o` is 0, no entry sequence starts: `push_req_o` stays 0 regardless of held requests and `insn_end_i`.
- R4: An entry starts only at an instruction boundary. If `gie_o` is 1, a request is held and `insn_end_i` is 1 in cycle t, the arbitration slot is cycle t+1 and `push_req_o` rises in cycle t+2. No entry starts while `insn_end_i` is 0.
- R5: The fixed priority from highest to lowest is `req_i[3]` (wake-up), `req_i[2]` (timer 0), `req_i[1]` (timer 1), `req_i[0]` (software). `vec_idx_o` equals the granted bit index: 3, 2, 1 or 0.
- R6: The push phase first shows `push_req_o`=1 with `push_hi_o`=0 (low byte), then `push_req_o`=1 with `push_hi_o`=1 (high byte). Each phase holds until `push_ack_i` is 1 at a clock edge. `vec_valid_o` is 1 for exactly the one cycle after the high-byte acknowledge, and `push_req_o` is 0 in that cycle.
- R7: Two cycles after the `vec_valid_o` cycle, `gie_o` is 0 and `in_service_o` is 1. The entry takes five cycles when both pushes are acknowledged at once.
- R8: Granting a source clears only that source's held request. Other held requests are serviced afterwards, in priority order.
- R9: `reti_i` sets `gie_o` to 1 from the next cycle and reduces the nesting count by one. The count saturates at zero, and `in_service_o` is 1 exactly while the count is non-zero.
- R10: `gie_set_i` is accepted during a service routine. A further interrupt can then be entered, which raises the nesting count, so two returns are needed before `in_service_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request lines; bit 3 wake-up, 2 timer 0, 1 timer 1, 0 software |
| insn_end_i | input | 1 | Current instruction has retired this cycle |
| gie_set_i | input | 1 | Command that sets the global enable |
| reti_i | input | 1 | Return-from-interrupt command |
| push_ack_i | input | 1 | Stack unit accepts the current push |
| push_req_o | output | 1 | Push of the return address requested |
| push_hi_o | output | 1 | 0 = low byte push, 1 = high byte push |
| vec_valid_o | output | 1 | Vector fetch cycle; `vec_idx_o` is to be used |
| vec_idx_o | output | 2 | Index of the granted source |
| gie_o | output | 1 | Global interrupt enable |
| in_service_o | output | 1 | At least one service routine is active |

## Verification
Each result has its own latency. A request reaches the pending store one edge after it is driven. An entry shows `push_req_o` two cycles after the qualifying boundary cycle. The vector appears one cycle after the high-byte acknowledge. The enable falls and the in-service flag rises two cycles after the vector cycle. A return raises the enable on the next cycle. The bench drives inputs on the falling edge and samples outputs on a later falling edge. It counts edges exactly to each of these due cycles, so every comparison is made in the cycle where the value is due. When the bench waits for an entry to start, it uses a bounded poll.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Entry sequencer states; the five non-idle states form the entry sequence.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARB     = 3'd1,
        ST_PUSH_LO = 3'd2,
        ST_PUSH_HI = 3'd3,
        ST_FETCH   = 3'd4,
        ST_MASK    = 3'd5
    } seq_state_e;

    // Source positions on the request bus (higher index wins).
    localparam int SRC_WAKE   = 3;
    localparam int SRC_TIMER0 = 2;
    localparam int SRC_TIMER1 = 1;
    localparam int SRC_SOFT   = 0;

endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] clr_i,
    output logic [N_SRC-1:0] pend_o
);

    logic [N_SRC-1:0] pend_d, pend_q;

    // A fresh request in the same cycle as its grant re-arms the bit.
    always_comb begin
        pend_d = (pend_q & ~clr_i) | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 4,
    localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] pend_i,
    output logic             any_o,
    output logic [IW-1:0]    idx_o,
    output logic [N_SRC-1:0] grant_o
);

    // A bit is granted when no higher-index bit is pending.
    for (genvar i = 0; i < N_SRC; i++) begin : g_grant
        if (i == N_SRC - 1) begin : g_top
            assign grant_o[i] = pend_i[i];
        end else begin : g_low
            assign grant_o[i] = pend_i[i] & ~(|pend_i[N_SRC-1:i+1]);
        end
    end

    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (grant_o[k]) idx_o = IW'(k);
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
#(
    parameter int IW      = 2,
    parameter int DEPTH_W = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_i,
    input  logic [IW-1:0] idx_i,
    input  logic          insn_end_i,
    input  logic          gie_set_i,
    input  logic          reti_i,
    input  logic          push_ack_i,
    output logic          take_o,
    output logic          push_req_o,
    output logic          push_hi_o,
    output logic          vec_valid_o,
    output logic [IW-1:0] vec_idx_o,
    output logic          gie_o,
    output logic          in_service_o
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;

    typedef struct packed {
        seq_state_e           state;
        logic [IW-1:0]        sel;
        logic                 gie;
        logic [DEPTH_W-1:0]   depth;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic      take;

    always_comb begin
        r_d  = r_q;
        take = (r_q.state == ST_IDLE) && r_q.gie && any_i && insn_end_i;

        if (gie_set_i || reti_i) r_d.gie = 1'b1;
        if (reti_i && (r_q.depth != '0)) r_d.depth = r_q.depth - 1'b1;

        unique case (r_q.state)
            ST_IDLE: begin
                if (take) begin
                    r_d.state = ST_ARB;
                    r_d.sel   = idx_i;
                end
            end
            ST_ARB:     r_d.state = ST_PUSH_LO;
            ST_PUSH_LO: if (push_ack_i) r_d.state = ST_PUSH_HI;
            ST_PUSH_HI: if (push_ack_i) r_d.state = ST_FETCH;
            ST_FETCH:   r_d.state = ST_MASK;
            ST_MASK: begin
                // Mask is dropped last, after stacking and vector fetch.
                r_d.gie   = 1'b0;
                r_d.state = ST_IDLE;
                if (r_d.depth != DEPTH_MAX) r_d.depth = r_d.depth + 1'b1;
            end
            default:    r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.sel   <= '0;
            r_q.gie   <= 1'b0;
            r_q.depth <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign take_o       = take;
    assign push_req_o   = (r_q.state == ST_PUSH_LO) || (r_q.state == ST_PUSH_HI);
    assign push_hi_o    = (r_q.state == ST_PUSH_HI);
    assign vec_valid_o  = (r_q.state == ST_FETCH);
    assign vec_idx_o    = r_q.sel;
    assign gie_o        = r_q.gie;
    assign in_service_o = (r_q.depth != '0);

endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
    parameter int N_SRC   = 4,
    parameter int DEPTH_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          req_i,
    input  logic                      insn_end_i,
    input  logic                      gie_set_i,
    input  logic                      reti_i,
    input  logic                      push_ack_i,
    output logic                      push_req_o,
    output logic                      push_hi_o,
    output logic                      vec_valid_o,
    output logic [$clog2(N_SRC)-1:0]  vec_idx_o,
    output logic                      gie_o,
    output logic                      in_service_o
);

    localparam int IW = $clog2(N_SRC);

    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] grant;
    logic [N_SRC-1:0] clr;
    logic             any;
    logic [IW-1:0]    idx;
    logic             take;

    irq_pending #(.N_SRC(N_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irq_prio_enc #(.N_SRC(N_SRC)) u_enc (
        .pend_i  (pend),
        .any_o   (any),
        .idx_o   (idx),
        .grant_o (grant)
    );

    // Only the granted source leaves the pending store.
    assign clr = take ? grant : '0;

    irq_seq #(.IW(IW), .DEPTH_W(DEPTH_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_i        (any),
        .idx_i        (idx),
        .insn_end_i   (insn_end_i),
        .gie_set_i    (gie_set_i),
        .reti_i       (reti_i),
        .push_ack_i   (push_ack_i),
        .take_o       (take),
        .push_req_o   (push_req_o),
        .push_hi_o    (push_hi_o),
        .vec_valid_o  (vec_valid_o),
        .vec_idx_o    (vec_idx_o),
        .gie_o        (gie_o),
        .in_service_o (in_service_o)
    );

endmodule

// File: rtl/irq_prio_ctl_chk.sv
module irq_prio_ctl_chk #(
    parameter int N_SRC = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     insn_end_i,
    input logic                     gie_set_i,
    input logic                     reti_i,
    input logic                     push_ack_i,
    input logic                     push_req_o,
    input logic                     push_hi_o,
    input logic                     vec_valid_o,
    input logic [$clog2(N_SRC)-1:0] vec_idx_o,
    input logic                     gie_o,
    input logic                     in_service_o
);

    // R3: a push can only begin after a cycle with the enable set.
    p_no_entry_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req_o) |-> $past(gie_o))
        else $error("p_no_entry_masked_r3");

    // R4: push phase begins two cycles after an instruction boundary.
    p_boundary_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req_o) |-> $past(insn_end_i, 2))
        else $error("p_boundary_start_r4");

    // R6: low byte precedes high byte.
    p_lo_then_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_o && !push_hi_o && push_ack_i) |=> (push_req_o && push_hi_o))
        else $error("p_lo_then_hi_r6");

    // R6: an unacknowledged push holds.
    p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_o && !push_ack_i) |=> (push_req_o && $stable(push_hi_o)))
        else $error("p_push_hold_r6");

    // R6: vector follows the acknowledged high-byte push.
    p_vec_after_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req_o && push_hi_o && push_ack_i) |=> (vec_valid_o && !push_req_o))
        else $error("p_vec_after_push_r6");

    // R5: the granted index does not move during the entry.
    p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_idx_o == $past(vec_idx_o)))
        else $error("p_vec_stable_r5");

    // R7: enable dropped and service flagged two cycles after the vector.
    p_mask_after_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> ##1 (!gie_o && in_service_o))
        else $error("p_mask_after_vec_r7");

    // R9 / R10: commands set the enable except in the masking slot.
    p_cmd_sets_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((reti_i || gie_set_i) && !$past(vec_valid_o)) |=> gie_o)
        else $error("p_cmd_sets_gie_r9");

endmodule

bind irq_prio_ctl irq_prio_ctl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .insn_end_i   (insn_end_i),
    .gie_set_i    (gie_set_i),
    .reti_i       (reti_i),
    .push_ack_i   (push_ack_i),
    .push_req_o   (push_req_o),
    .push_hi_o    (push_hi_o),
    .vec_valid_o  (vec_valid_o),
    .vec_idx_o    (vec_idx_o),
    .gie_o        (gie_o),
    .in_service_o (in_service_o)
);

// File: tb/irq_prio_ctl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0;
    logic       insn_end_i = 1'b0;
    logic       gie_set_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       push_ack_i = 1'b0;
    logic       push_req_o, push_hi_o, vec_valid_o, gie_o, in_service_o;
    logic [1:0] vec_idx_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_prio_ctl u_irq_prio_ctl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .insn_end_i(insn_end_i),
        .gie_set_i(gie_set_i), .reti_i(reti_i), .push_ack_i(push_ack_i),
        .push_req_o(push_req_o), .push_hi_o(push_hi_o), .vec_valid_o(vec_valid_o),
        .vec_idx_o(vec_idx_o), .gie_o(gie_o), .in_service_o(in_service_o)
    );

    // {pattern[14:11], count[10:8], service order[7:0], first index in [7:6]}
    localparam logic [14:0] VEC_TBL [8] = '{
        {4'b0001, 3'd1, 8'h00},
        {4'b1000, 3'd1, 8'hC0},
        {4'b0110, 3'd2, 8'h90},
        {4'b1001, 3'd2, 8'hC0},
        {4'b1111, 3'd4, 8'hE4},
        {4'b0101, 3'd2, 8'h80},
        {4'b0010, 3'd1, 8'h40},
        {4'b1100, 3'd2, 8'hE0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [3:0] pat);
        req_i = pat;
        @(negedge clk);
        req_i = '0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1;
        @(negedge clk);
        reti_i = 1'b0;
        chk("R9 gie after return", gie_o, 1);
    endtask

    // Called at a negedge; runs one entry with the given low-byte stall.
    task automatic do_entry(input int stall, output logic [1:0] got);
        got = '0;
        for (int w = 0; w < 10 && !push_req_o; w++) @(negedge clk);
        chk("R6 entry started", push_req_o, 1);
        chk("R6 low byte first", push_hi_o, 0);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R6 low push held", {push_req_o, push_hi_o}, 2);
        end
        push_ack_i = 1'b1;
        @(negedge clk);
        chk("R6 high byte", {push_req_o, push_hi_o}, 3);
        @(negedge clk);
        push_ack_i = 1'b0;
        chk("R6 vector valid", {vec_valid_o, push_req_o}, 2);
        got = vec_idx_o;
        @(negedge clk);
        chk("R6 vector one cycle", vec_valid_o, 0);
        @(negedge clk);
        chk("R7 gie cleared", gie_o, 0);
        chk("R7 in service", in_service_o, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 gie reset", gie_o, 0);
        chk("R1 push reset", push_req_o, 0);
        chk("R1 vec reset", vec_valid_o, 0);
        chk("R1 service reset", in_service_o, 0);

        // R3 and R2: request while masked stays pending
        insn_end_i = 1'b1;
        pulse_req(4'b0010);
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R3 no entry while masked", push_req_o, 0);
        end

        // R4: enabled but no boundary
        insn_end_i = 1'b0;
        gie_set_i = 1'b1;
        @(negedge clk);
        gie_set_i = 1'b0;
        chk("R4 gie set", gie_o, 1);
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R4 no entry without boundary", push_req_o, 0);
        end
        insn_end_i = 1'b1;
        @(negedge clk);
        chk("R4 arbitration slot quiet", push_req_o, 0);
        @(negedge clk);
        chk("R4 push two cycles after boundary", push_req_o, 1);
        do_entry(3, got);
        chk("R2 held request serviced", got, 1);
        do_reti();
        chk("R9 service ends", in_service_o, 0);

        // R5 / R8: table of request patterns
        foreach (VEC_TBL[v]) begin
            logic [3:0] pat;
            int         cnt;
            pat = VEC_TBL[v][14:11];
            cnt = int'(VEC_TBL[v][10:8]);
            insn_end_i = 1'b0;
            pulse_req(pat);
            insn_end_i = 1'b1;
            for (int k = 0; k < cnt; k++) begin
                do_entry(0, got);
                chk((k == 0) ? "R5 priority winner" : "R8 queued order",
                    got, int'(VEC_TBL[v][7-2*k -: 2]));
                do_reti();
            end
            repeat (4) begin
                @(negedge clk);
                chk("R8 queue drained", push_req_o, 0);
            end
        end

        // R10: nesting
        pulse_req(4'b0001);
        do_entry(0, got);
        chk("R10 outer source", got, 0);
        gie_set_i = 1'b1;
        @(negedge clk);
        gie_set_i = 1'b0;
        chk("R10 gie set in service", gie_o, 1);
        pulse_req(4'b1000);
        do_entry(1, got);
        chk("R10 nested source", got, 3);
        do_reti();
        chk("R10 still in service after one return", in_service_o, 1);
        do_reti();
        chk("R9 service ends after two returns", in_service_o, 0);
        do_reti();
        chk("R9 count saturates at zero", in_service_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule